// File: doc/BRIEF.md
# Lane Request Coalescer

This block gathers the memory requests of a 16-lane group into a small set of aligned segment transactions. Each lane presents an enable bit and a byte start address. The whole group shares one element-size code. The block latches the group, then loops. Each pass takes the lowest lane still pending and finds the aligned segment around that lane's address. It sweeps in every other pending lane that falls in the same segment. It narrows the transaction where the start addresses allow, offers the result on the transaction port, and retires those lanes once the memory side grants it. When every lane has been served, a one-cycle done pulse marks the end of the group.

A strict input selects a legacy rule. Under this rule the group merges only when every enabled lane k sits at word k of one aligned segment. Any other pattern is split into one transaction per enabled lane. The block moves no data and models no memory. It emits only descriptors: base address, byte count and lane mask.

Both edges of the block use valid/ready handshakes. A group is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. While busy, the request inputs are ignored. A transaction is presented with `txn_valid` and stays unchanged until `txn_ready` is seen high on a clock edge. The consumer may hold `txn_ready` low for any number of cycles.

Top module: `mem_coalescer`

## Requirements
- R1: `req_ready` is 1 exactly when the block is idle. A group is latched only on a clock edge with `req_valid` and `req_ready` both high. Request inputs seen while busy do not change the transactions of the group in progress.
- R2: The segment size follows `req_esize`: code 0 (1-byte elements) gives 32 bytes, code 1 (2-byte) gives 64 bytes, and codes 2, 3 and 4 and above (4, 8 and 16 bytes) give 128 bytes.
- R3: Each transaction starts from the lowest-numbered pending lane. Its segment base is that lane's address rounded down to a multiple of the segment size. The mask holds every pending lane whose address lies in that segment.
- R4: For a 128-byte segment, if all masked start addresses share address bit 6, the transaction becomes 64 bytes at that half. If they then also share bit 5, it becomes 32 bytes at that quarter. Segments of 32 and 64 bytes are issued at full size.
- R5: Lanes leave the pending set only when their transaction is granted. Every enabled lane appears in exactly one transaction of its group, and transaction masks are never empty.
- R6: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base`, `txn_bytes` and `txn_mask` hold their values on the next cycle.
- R7: In strict mode, if every enabled lane k has address B + k*E, where E is the element size (1, 2, 4, 8, 16 for codes 0..4+), B is a multiple of the segment size, and all those addresses lie in the segment at B, then one transaction covers all enabled lanes. That transaction is still narrowed by R4.
- R8: In strict mode, a pattern that fails R7 is issued as one single-lane transaction per enabled lane, in ascending lane order, each sized by R2 and R4.
- R9: `done` pulses high for exactly one cycle, in the cycle after the last grant of a group. A group with no enabled lane produces no transaction and pulses `done` in the cycle after it is latched.
- R10: After reset, `req_ready` is 1 and `txn_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request group offered |
| req_ready | output | 1 | Block idle, group can be taken |
| req_strict | input | 1 | 1 selects the strict ordered-pattern rule |
| req_esize | input | 3 | Element size code, 0..4 for 1..16 bytes |
| req_active | input | 16 | Per-lane enable |
| req_addr | input | 512 | Per-lane byte address, lane k in bits [32k+31:32k] |
| txn_valid | output | 1 | Transaction descriptor offered |
| txn_ready | input | 1 | Memory side grants the transaction |
| txn_base | output | 32 | Aligned transaction base address |
| txn_bytes | output | 8 | Transaction size: 32, 64 or 128 |
| txn_mask | output | 16 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after the last grant |

## Verification
Every cycle, the assertions check the handshake hold rule, base alignment to the issued size, that the issued size is a legal power of two, that masks are non-empty and drawn only from pending lanes, that granted lanes leave the pending set, the single-lane shape of strict fallback, and that done appears only while idle. The exact transaction order, the base and mask chosen by the lowest-lane search, the half and quarter narrowing, and strict pass versus fail on real address patterns can only be shown by the bench's scenarios. The same holds for ignoring request inputs while busy and for the done pulse of an empty group. The bench compares each of these against its own model under random stalls on the grant.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;

  // log2 of the segment size for an element-size code
  function automatic logic [2:0] seg_log2(input logic [2:0] esz);
    case (esz)
      3'd0:    seg_log2 = 3'd5;
      3'd1:    seg_log2 = 3'd6;
      default: seg_log2 = 3'd7;
    endcase
  endfunction

  // log2 of the element size for an element-size code
  function automatic logic [2:0] elem_log2(input logic [2:0] esz);
    elem_log2 = (esz > 3'd4) ? 3'd4 : esz;
  endfunction

endpackage

// File: rtl/coal_strict_chk.sv
module coal_strict_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    active,
  input  logic [LANES*AW-1:0] addr,
  input  logic [2:0]          esz,
  output logic                ok
);
  import coal_pkg::*;

  logic [2:0]    slog;
  logic [2:0]    elog;
  logic [AW-1:0] smask;

  assign slog  = seg_log2(esz);
  assign elog  = elem_log2(esz);
  assign smask = (AW'(1) << slog) - AW'(1);

  always_comb begin
    logic          seen;
    logic [AW-1:0] pat_base;
    logic [AW-1:0] cand;
    logic [AW-1:0] a;
    seen     = 1'b0;
    pat_base = '0;
    ok       = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      a    = addr[k*AW +: AW];
      cand = a - (AW'(k) << elog);
      if (active[k]) begin
        if (!seen) begin
          seen     = 1'b1;
          pat_base = cand;
          if ((cand & smask) != '0) ok = 1'b0;
        end else if (cand != pat_base) begin
          ok = 1'b0;
        end
        if ((a >> slog) != (pat_base >> slog)) ok = 1'b0;
      end
    end
  end

endmodule

// File: rtl/coal_picker.sv
module coal_picker #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    pending,
  input  logic [LANES*AW-1:0] addr,
  input  logic [2:0]          slog,
  input  logic                strict,
  input  logic                strict_ok,
  output logic [LANES-1:0]    mask,
  output logic [AW-1:0]       seg_base
);

  logic [AW-1:0]    smask;
  logic [AW-1:0]    lead_addr;
  logic [LANES-1:0] lead_hot;
  logic [LANES-1:0] in_seg;

  assign smask    = (AW'(1) << slog) - AW'(1);
  assign lead_hot = pending & (~pending + LANES'(1));

  always_comb begin
    lead_addr = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (pending[k]) lead_addr = addr[k*AW +: AW];
    end
  end

  assign seg_base = lead_addr & ~smask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_seg[g] = pending[g] && ((addr[g*AW +: AW] & ~smask) == seg_base);
  end

  always_comb begin
    if (!strict)        mask = in_seg;
    else if (strict_ok) mask = pending;
    else                mask = lead_hot;
  end

endmodule

// File: rtl/coal_shrink.sv
module coal_shrink #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    mask,
  input  logic [LANES*AW-1:0] addr,
  input  logic [AW-1:0]       seg_base,
  input  logic [2:0]          slog,
  output logic [AW-1:0]       base,
  output logic [7:0]          bytes
);

  logic hi6, lo6, hi5, lo5;
  logic same6, same5;

  always_comb begin
    hi6 = 1'b0; lo6 = 1'b0; hi5 = 1'b0; lo5 = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (mask[k]) begin
        if (addr[k*AW + 6]) hi6 = 1'b1; else lo6 = 1'b1;
        if (addr[k*AW + 5]) hi5 = 1'b1; else lo5 = 1'b1;
      end
    end
  end

  assign same6 = !(hi6 && lo6);
  assign same5 = !(hi5 && lo5);

  always_comb begin
    base  = seg_base;
    bytes = 8'd1 << slog;
    if (slog == 3'd7 && same6) begin
      base[6] = hi6;
      bytes   = 8'd64;
      if (same5) begin
        base[5] = hi5;
        bytes   = 8'd32;
      end
    end
  end

endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_strict,
  input  logic [2:0]          req_esize,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [7:0]          txn_bytes,
  output logic [LANES-1:0]    txn_mask,
  output logic                done
);
  import coal_pkg::*;

  coal_state_e         state;
  logic [LANES-1:0]    pending;
  logic [LANES*AW-1:0] addr_r;
  logic [2:0]          esz_r;
  logic                strict_r;
  logic                sok_r;
  logic                sok_in;
  logic [2:0]          slog;
  logic [AW-1:0]       seg_base;
  logic [LANES-1:0]    left;

  assign slog      = seg_log2(esz_r);
  assign req_ready = (state == ST_IDLE);
  assign txn_valid = (state == ST_BUSY);
  assign left      = pending & ~txn_mask;

  coal_strict_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .active (req_active),
    .addr   (req_addr),
    .esz    (req_esize),
    .ok     (sok_in)
  );

  coal_picker #(.LANES(LANES), .AW(AW)) u_pick (
    .pending   (pending),
    .addr      (addr_r),
    .slog      (slog),
    .strict    (strict_r),
    .strict_ok (sok_r),
    .mask      (txn_mask),
    .seg_base  (seg_base)
  );

  coal_shrink #(.LANES(LANES), .AW(AW)) u_shrink (
    .mask     (txn_mask),
    .addr     (addr_r),
    .seg_base (seg_base),
    .slog     (slog),
    .base     (txn_base),
    .bytes    (txn_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pending  <= '0;
      addr_r   <= '0;
      esz_r    <= '0;
      strict_r <= 1'b0;
      sok_r    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_r   <= req_addr;
            esz_r    <= req_esize;
            strict_r <= req_strict;
            sok_r    <= sok_in;
            pending  <= req_active;
            if (req_active != '0) state <= ST_BUSY;
            else                  done  <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (txn_ready) begin
            pending <= left;
            if (left == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) &&
      $stable(txn_bytes) && $stable(txn_mask));

  // R3
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_base & AW'(txn_bytes - 8'd1)) == '0));

  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ($countones(txn_bytes) == 1 && txn_bytes >= 8'd32));

  // R5
  mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask != '0 && (txn_mask & ~pending) == '0));

  // R5
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready |=> (pending & $past(txn_mask)) == '0);

  // R8
  strict_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && strict_r && !sok_r |-> $onehot(txn_mask));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !txn_valid);

endmodule

// File: tb/mem_coalescer_tb.sv
`timescale 1ns/1ps
module mem_coalescer_tb;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic                req_strict = 1'b0;
  logic [2:0]          req_esize = '0;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic                txn_valid;
  logic                txn_ready = 1'b0;
  logic [AW-1:0]       txn_base;
  logic [7:0]          txn_bytes;
  logic [LANES-1:0]    txn_mask;
  logic                done;

  always #2.5 clk = ~clk;

  mem_coalescer #(.LANES(LANES), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_strict(req_strict), .req_esize(req_esize), .req_active(req_active),
    .req_addr(req_addr), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_base(txn_base), .txn_bytes(txn_bytes), .txn_mask(txn_mask), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [AW-1:0]    b_addr [LANES];
  logic [LANES-1:0] b_act;
  logic [2:0]       b_esz;
  logic             b_strict;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int seg_bytes(input logic [2:0] e);
    if (e == 3'd0) return 32;
    if (e == 3'd1) return 64;
    return 128;
  endfunction

  function automatic int elem_bytes(input logic [2:0] e);
    case (e)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic bit strict_pass();
    int S = seg_bytes(b_esz);
    int E = elem_bytes(b_esz);
    bit first = 1'b1;
    longint B = 0;
    for (int k = 0; k < LANES; k++) begin
      if (b_act[k]) begin
        if (first) begin
          first = 1'b0;
          B = longint'(b_addr[k]) - k * E;
          if (B < 0 || (B % S) != 0) return 1'b0;
        end
        if (longint'(b_addr[k]) != B + k * E) return 1'b0;
        if ((longint'(b_addr[k]) / S) != (B / S)) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  task automatic model_next(input logic [LANES-1:0] pend, input bit sok,
                            output logic [AW-1:0] base, output int bytes,
                            output logic [LANES-1:0] mask);
    int S = seg_bytes(b_esz);
    int L = 0;
    logic [AW-1:0] seg;
    bit b6_0, b6_1, b5_0, b5_1;
    for (int k = LANES - 1; k >= 0; k--) if (pend[k]) L = k;
    seg = b_addr[L] - (b_addr[L] % S);
    mask = '0;
    if (b_strict) begin
      if (sok) mask = pend; else mask[L] = 1'b1;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (pend[k] && (b_addr[k] / S) == (b_addr[L] / S)) mask[k] = 1'b1;
    end
    base = seg; bytes = S;
    b6_0 = 0; b6_1 = 0; b5_0 = 0; b5_1 = 0;
    for (int k = 0; k < LANES; k++) if (mask[k]) begin
      if ((b_addr[k] % 128) >= 64) b6_1 = 1; else b6_0 = 1;
      if ((b_addr[k] % 64) >= 32) b5_1 = 1; else b5_0 = 1;
    end
    if (S == 128 && !(b6_0 && b6_1)) begin
      bytes = 64;
      if (b6_1) base = base + 64;
      if (!(b5_0 && b5_1)) begin
        bytes = 32;
        if (b5_1) base = base + 32;
      end
    end
  endtask

  // Runs one group from the b_* arrays; called at a negedge with the block idle.
  task automatic run_group(input string tag_main);
    logic [LANES-1:0] pend;
    logic [LANES-1:0] em;
    logic [AW-1:0]    eb;
    int               ebytes;
    bit               sok;
    bit               g;
    string            tag;
    sok = strict_pass();
    for (int k = 0; k < LANES; k++) req_addr[k*AW +: AW] = b_addr[k];
    req_active = b_act; req_esize = b_esz; req_strict = b_strict;
    req_valid = 1'b1;
    check(req_ready == 1'b1, "R1", "ready while idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    pend = b_act;
    if (b_act == '0) begin
      req_valid = 1'b0;
      check(done == 1'b1, "R9", "done after empty group", done, 1);
      check(txn_valid == 1'b0, "R9", "no txn for empty group", txn_valid, 0);
      @(negedge clk);
      check(done == 1'b0, "R9", "done pulse width", done, 0);
      return;
    end
    while (pend != '0) begin
      // R1: scramble request inputs while busy; they must be ignored
      req_valid = 1'($urandom % 2);
      req_active = LANES'($urandom);
      req_addr[AW-1:0] = $urandom;
      req_strict = 1'($urandom % 2);
      check(req_ready == 1'b0, "R1", "ready while busy", req_ready, 0);
      check(done == 1'b0, "R9", "done while busy", done, 0);
      model_next(pend, sok, eb, ebytes, em);
      tag = b_strict ? (sok ? "R7" : "R8") : tag_main;
      check(txn_valid == 1'b1, "R5", "txn_valid while lanes pending", txn_valid, 1);
      check(txn_mask == em, tag, "txn_mask", txn_mask, em);
      check(txn_base == eb, tag, "txn_base", txn_base, eb);
      check(int'(txn_bytes) == ebytes, (ebytes < seg_bytes(b_esz)) ? "R4" : "R2",
            "txn_bytes", txn_bytes, ebytes);
      g = ($urandom % 3) != 0;
      txn_ready = g;
      @(posedge clk);
      @(negedge clk);
      txn_ready = 1'b0;
      if (g) pend = pend & ~em;
    end
    req_valid = 1'b0;
    check(done == 1'b1, "R9", "done after last grant", done, 1);
    check(req_ready == 1'b1, "R9", "idle after last grant", req_ready, 1);
    check(txn_valid == 1'b0, "R5", "no txn after group", txn_valid, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done pulse width", done, 0);
  endtask

  task automatic set_linear(input logic [AW-1:0] base, input int stride,
                            input logic [LANES-1:0] act);
    for (int k = 0; k < LANES; k++) b_addr[k] = base + AW'(k * stride);
    b_act = act;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10", "req_ready in reset", req_ready, 1);
    check(txn_valid == 1'b0, "R10", "txn_valid in reset", txn_valid, 0);
    check(done == 1'b0, "R10", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);

    // R2/R3: 4-byte unit stride fills one 128-byte segment
    b_esz = 3'd2; b_strict = 1'b0;
    set_linear(32'h1000, 4, '1);
    run_group("R3");
    // R4: lanes 0..7 within one 32-byte quarter
    set_linear(32'h1040, 4, 16'h00FF);
    run_group("R4");
    // R4: upper half only, spanning two quarters
    set_linear(32'h10C0, 4, 16'hFFFF);
    run_group("R4");
    // R2/R3: byte elements with stride 8 give several 32-byte segments
    b_esz = 3'd0;
    set_linear(32'h2003, 8, 16'hFFFF);
    run_group("R3");
    // R3: broadcast of one address
    b_esz = 3'd3;
    set_linear(32'h3010, 0, 16'hA5A5);
    run_group("R3");
    // R9: empty group
    set_linear(32'h0, 4, 16'h0000);
    run_group("R9");
    // R7: strict ordered aligned pattern, lane 0 disabled
    b_strict = 1'b1; b_esz = 3'd2;
    set_linear(32'h4000, 4, 16'hFFFE);
    run_group("R7");
    // R8: strict with two lanes swapped
    set_linear(32'h4000, 4, 16'hFFFF);
    b_addr[1] = 32'h4008; b_addr[2] = 32'h4004;
    run_group("R8");
    // R8: strict with 16-byte elements overflows the segment
    b_esz = 3'd4;
    set_linear(32'h5000, 16, 16'hFFFF);
    run_group("R8");
    // R8: strict with misaligned base
    b_esz = 3'd1;
    set_linear(32'h6002, 2, 16'h0FFF);
    run_group("R8");

    // Constrained random groups
    for (int n = 0; n < 60; n++) begin
      int kind;
      logic [AW-1:0] bs;
      kind = $urandom % 4;
      b_esz = 3'($urandom % 5);
      b_strict = 1'($urandom % 2);
      bs = ($urandom % 4096) & ~AW'(elem_bytes(b_esz) - 1);
      if (kind == 0) begin
        bs = bs & ~AW'(seg_bytes(b_esz) - 1);
        set_linear(bs, elem_bytes(b_esz), LANES'($urandom));
      end else if (kind == 1) begin
        set_linear(bs, elem_bytes(b_esz) * (1 + $urandom % 3), LANES'($urandom));
      end else begin
        b_act = LANES'($urandom);
        for (int k = 0; k < LANES; k++)
          b_addr[k] = bs + AW'(($urandom % 256) & ~(elem_bytes(b_esz) - 1));
      end
      run_group(b_strict ? "R8" : "R3");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule